// File: doc/BRIEF.md
# Idle Countdown Timer

This block measures how long a system has gone without activity and raises a one-cycle expiry pulse toward an interrupt controller once a programmed idle interval has fully elapsed. Software sets a start count and one of four tick rates through a small register write port. A prescaler divides the clock down to the selected tick rate, and the counter steps down by one on every tick.

Activity is reported on an event vector, which an 8-bit enable mask filters. Any enabled activity bit loads the start count back into the counter and restarts the prescaler, so an interval is always measured from the most recent qualifying activity. A start count of zero turns the timer off.

Top module: `idle_timer`

## Requirements
- R1: Synchronous active-high reset leaves expiry low, the start count at zero (timer disabled), the rate code at 0 and every activity-enable bit set.
- R2: Address 0 writes the start count from wr_data. The write loads the counter and restarts the prescaler on the same edge. With start count S and tick period P, the expiry pulse follows exactly S*P clock edges after the write edge.
- R3: Address 1 writes the rate code from wr_data[1:0]. Code c gives a tick period of 2^(RATE_SHIFT*c) clocks, which is 1, 16, 256 or 4096 at the default RATE_SHIFT of 4.
- R4: An activity bit that is high at a clock edge while its enable bit is set reloads the stored start count and restarts the prescaler. Expiry then follows S*P edges after that edge.
- R5: Address 2 writes the activity-enable mask from wr_data[7:0], where bit i enables activity bit i. A high activity bit whose enable bit is clear has no effect on timing.
- R6: Expiry lasts exactly one cycle. The counter then stays at zero and no further pulse occurs until a reload or a start-count write.
- R7: While the start count is zero, no expiry is ever produced, whatever activity arrives.
- R8: When a reload and a tick fall on the same edge, the reload wins. No expiry follows that edge, and the next interval starts from the full start count.
- R9: A rate write restarts the prescaler and keeps the current count C. Expiry then follows C*Pnew edges after the rate-write edge.
- R10: A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 start count, 1 rate code, 2 activity mask, 3 unused |
| wr_data | input | DATA_W | Write data |
| activity_i | input | EVT_W | Activity event bits |
| expire_o | output | 1 | One-cycle idle expiry pulse |

## Verification
The hardest case to reach is a reload landing on exactly the edge where the counter would step from one to zero. The bench reaches it by starting a short count at a known edge, counting edges to the final tick, and raising an enabled activity bit on that edge. It does this at a tick period of one and also at a longer period. A rate change in the middle of a countdown is produced the same way, by counting edges from the start write. The expected expiry edge is then worked out from the count that remains.

// File: rtl/idle_timer_pkg.sv
package idle_timer_pkg;
  typedef enum logic [1:0] {
    REG_START = 2'd0,
    REG_RATE  = 2'd1,
    REG_MASK  = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;

  typedef logic [1:0] rate_t;
  localparam int NUM_RATES = 4;
endpackage

// File: rtl/idle_regs.sv
module idle_regs
  import idle_timer_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int EVT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [EVT_W-1:0]  activity_i,
  output logic [CNT_W-1:0]  start_val,
  output logic              load_new,
  output logic [CNT_W-1:0]  load_data,
  output logic              evt_hit,
  output rate_t             rate_q,
  output logic              rate_chg
);
  reg_addr_e           sel;
  logic [EVT_W-1:0]    mask_q;
  logic [CNT_W-1:0]    start_q;
  logic                unused_wdata_hi;

  assign sel             = reg_addr_e'(wr_addr);
  assign load_new        = wr_en && (sel == REG_START);
  assign rate_chg        = wr_en && (sel == REG_RATE);
  assign load_data       = wr_data[CNT_W-1:0];
  assign evt_hit         = |(activity_i & mask_q);
  assign start_val       = start_q;
  assign unused_wdata_hi = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      rate_q  <= '0;
      mask_q  <= '1;
    end else if (wr_en) begin
      case (sel)
        REG_START: start_q <= wr_data[CNT_W-1:0];
        REG_RATE:  rate_q  <= wr_data[1:0];
        REG_MASK:  mask_q  <= wr_data[EVT_W-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/idle_prescaler.sv
module idle_prescaler
  import idle_timer_pkg::*;
#(
  parameter int RATE_SHIFT = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  restart,
  input  rate_t rate,
  output logic  tick
);
  localparam int PRE_W = (NUM_RATES - 1) * RATE_SHIFT;

  logic [PRE_W-1:0]     pre_q;
  logic [NUM_RATES-1:0] at_limit;

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_lim
    localparam logic [PRE_W-1:0] LIM = PRE_W'((64'd1 << (g * RATE_SHIFT)) - 64'd1);
    assign at_limit[g] = (pre_q == LIM);
  end

  assign tick = at_limit[rate];

  always_ff @(posedge clk) begin
    if (rst || restart || tick) pre_q <= '0;
    else                        pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/idle_countdown.sv
module idle_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_new,
  input  logic [CNT_W-1:0] load_data,
  input  logic             evt_hit,
  input  logic [CNT_W-1:0] start_val,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             reload;
  logic             last_step;

  assign reload    = load_new || evt_hit;
  assign last_step = tick && (cnt_q == CNT_W'(1)) && !reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= last_step;
      if (load_new)                         cnt_q <= load_data;
      else if (evt_hit)                     cnt_q <= start_val;
      else if (tick && (cnt_q != '0))       cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/idle_timer.sv
module idle_timer
  import idle_timer_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int EVT_W      = 8,
  parameter int DATA_W     = 8,
  parameter int RATE_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [EVT_W-1:0]  activity_i,
  output logic              expire_o
);
  logic [CNT_W-1:0] start_val;
  logic [CNT_W-1:0] load_data;
  logic             load_new;
  logic             evt_hit;
  logic             rate_chg;
  logic             tick;
  rate_t            rate_q;

  idle_regs #(.CNT_W(CNT_W), .EVT_W(EVT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .activity_i(activity_i), .start_val(start_val), .load_new(load_new),
    .load_data(load_data), .evt_hit(evt_hit), .rate_q(rate_q), .rate_chg(rate_chg)
  );

  idle_prescaler #(.RATE_SHIFT(RATE_SHIFT)) u_pre (
    .clk(clk), .rst(rst), .restart(load_new || evt_hit || rate_chg),
    .rate(rate_q), .tick(tick)
  );

  idle_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load_new(load_new), .load_data(load_data),
    .evt_hit(evt_hit), .start_val(start_val), .expire_o(expire_o)
  );
endmodule

// File: rtl/idle_timer_chk.sv
module idle_timer_chk #(
  parameter int CNT_W  = 8,
  parameter int EVT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [EVT_W-1:0]  activity_i,
  input logic              expire_o
);
  logic [EVT_W-1:0] mask_sh;
  logic             zero_sh;
  logic             unused_chk;

  assign unused_chk = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_sh <= '1;
      zero_sh <= 1'b1;
    end else if (wr_en) begin
      if (wr_addr == 2'd2) mask_sh <= wr_data[EVT_W-1:0];
      if (wr_addr == 2'd0) zero_sh <= (wr_data[CNT_W-1:0] == '0);
    end
  end

  a_r1_known: assert property (@(posedge clk) disable iff (rst) !$isunknown(expire_o));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst) expire_o |=> !expire_o);
  a_r7_zero_silent: assert property (@(posedge clk) disable iff (rst) zero_sh |-> !expire_o);
  a_r2_write_restarts: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0) |=> !expire_o);
  a_r8_reload_wins: assert property (@(posedge clk) disable iff (rst)
    (|(activity_i & mask_sh)) |=> !expire_o);
endmodule

bind idle_timer idle_timer_chk #(.CNT_W(CNT_W), .EVT_W(EVT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .activity_i(activity_i), .expire_o(expire_o)
);

// File: tb/sim_idle_timer.sv
`timescale 1ns/1ps
module sim_idle_timer;
  localparam int RS = 2;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] act = '0;
  logic       expire_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  idle_timer #(.CNT_W(8), .EVT_W(8), .DATA_W(8), .RATE_SHIFT(RS)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .activity_i(act), .expire_o(expire_o)
  );

  task automatic chk(input bit ok, input string tag, input int a, input int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic pulse_act(input logic [7:0] v);
    @(negedge clk); act = v;
    @(posedge clk); #1; act = '0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  // expiry expected n edges after the current reference edge
  task automatic exp_at(input int n, input string tag);
    int lows = 0;
    for (int i = 1; i < n; i++) begin @(posedge clk); #1; if (expire_o) lows++; end
    chk(lows == 0, {tag, " early pulse"}, lows, 0);
    @(posedge clk); #1; chk(expire_o == 1'b1, {tag, " pulse"}, int'(expire_o), 1);
    @(posedge clk); #1; chk(expire_o == 1'b0, {tag, " width"}, int'(expire_o), 0);
  endtask

  task automatic quiet(input int n, input string tag);
    int hits = 0;
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; if (expire_o) hits++; end
    chk(hits == 0, tag, hits, 0);
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    edges(3);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state, disabled, rate 0, mask all ones
    chk(expire_o == 1'b0, "R1 expire after reset", int'(expire_o), 0);
    quiet(20, "R1 disabled after reset");
    wr(2'd0, 8'd2);
    exp_at(2, "R1 default rate");
    pulse_act(8'h80);
    exp_at(2, "R1 default mask");

    // R2/R3: sweep rates and start counts
    for (int r = 0; r < 4; r++) begin
      for (int s = 1; s <= 5; s += 2) begin
        wr(2'd1, 8'(r));
        wr(2'd0, 8'(s));
        exp_at(s * (1 << (RS * r)), $sformatf("R3 R2 rate=%0d s=%0d", r, s));
      end
    end
    wr(2'd1, 8'd0);
    wr(2'd0, 8'd255);
    exp_at(255, "R2 full count");

    // R6: hold at zero, then reload again
    quiet(60, "R6 no repeat pulse");
    pulse_act(8'h01);
    exp_at(255, "R6 reload after hold");

    // R4/R5: every mask bit against every activity bit
    for (int b = 0; b < 8; b++) begin
      for (int j = 0; j < 8; j++) begin
        wr(2'd2, 8'(1 << b));
        wr(2'd0, 8'd3);
        pulse_act(8'(1 << j));
        if (j == b) exp_at(3, $sformatf("R4 bit=%0d", j));
        else        exp_at(2, $sformatf("R5 mask=%0d bit=%0d", b, j));
      end
    end
    wr(2'd2, 8'hFF);

    // R8: reload on the final tick, rate 0
    wr(2'd0, 8'd3);
    edges(2);
    pulse_act(8'h04);
    chk(expire_o == 1'b0, "R8 coincide rate0", int'(expire_o), 0);
    exp_at(3, "R8 restart rate0");
    // R8: rate 1, final tick at edge 2*4 after write
    wr(2'd1, 8'd1);
    wr(2'd0, 8'd2);
    edges(7);
    pulse_act(8'h10);
    chk(expire_o == 1'b0, "R8 coincide rate1", int'(expire_o), 0);
    exp_at(8, "R8 restart rate1");

    // R9: rate change mid-count keeps count, restarts prescaler
    wr(2'd1, 8'd0);
    wr(2'd0, 8'd10);
    edges(3);
    wr(2'd1, 8'd1);
    exp_at(6 * 4, "R9 rate change");

    // R10: address 3 ignored
    wr(2'd1, 8'd0);
    wr(2'd0, 8'd5);
    wr(2'd3, 8'd0);
    exp_at(4, "R10 unused address");

    // R7: zero start never expires
    wr(2'd0, 8'd0);
    for (int k = 0; k < 8; k++) begin
      pulse_act(8'(1 << k));
      edges(5);
    end
    quiet(200, "R7 zero start");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule